// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Calibrator

This block trims an on-chip oscillator against a slow, accurate reference clock. It runs in the oscillator clock domain and counts the oscillator cycles that fall between two rising edges of the reference. It compares that count with a programmable target. After each reference period it moves a calibration code one step toward the target. The code drives the analog trim of the oscillator directly.

Software reaches two registers through a simple write port: the target count and the calibration code. Some rules depend on the loop enable. A manual trim write is accepted only while the loop is off. The target count can be changed at any time to retarget the frequency. While the loop runs, the reference source is held on. While the oscillator is stopped for sleep the whole loop freezes. The code is reloaded to its default only when the loop was off on entry to sleep and is switched on after wake-up.

Top module: `freq_lock_cal`

## Requirements
- R1: After reset, `cal_o` equals CAL_RST, `cmp_o` equals CMP_RST and `ref_dis_o` is 0.
- R2: With the loop enabled and awake, each synchronised rising edge of `ref_i` yields a measured count. This count is the number of `clk_i` cycles since the previous such edge. If the count is greater than `cmp_o`, `cal_o` decreases by 1. If it is smaller, `cal_o` increases by 1. If it is equal, `cal_o` holds. There is at most one step per edge.
- R3: `cal_o` saturates at 0 and at 2^CAL_W-1 and never wraps.
- R4: The first reference edge after `enable_i` rises only starts a period and causes no step.
- R5: A write with `reg_sel_i`=0 loads `reg_wdata_i` into `cmp_o` whether the loop is enabled or not.
- R6: A write with `reg_sel_i`=1 loads the low CAL_W bits of `reg_wdata_i` into `cal_o` only while `enable_i` is 0. While `enable_i` is 1 the write is ignored.
- R7: While `sleep_i` is 1, no register changes: steps, writes and reference edges are all ignored. After wake-up, `cal_o` keeps the value it held before sleep.
- R8: If `enable_i` was 0 when sleep was entered and rises after wake-up, `cal_o` is reloaded with CAL_RST.
- R9: A rise of `enable_i` with no such disabled sleep before it leaves `cal_o` unchanged.
- R10: `ref_dis_o` follows `ref_dis_req_i` one cycle later, but it is forced to 0 whenever `enable_i` was 1 in the previous cycle.
- R11: The measured count saturates at 2^CMP_W-1. A longer period is therefore measured as that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock, asynchronous |
| enable_i | input | 1 | Loop enable |
| sleep_i | input | 1 | Oscillator stopped by sleep |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: target count, 1: calibration code |
| reg_wdata_i | input | CMP_W | Write data |
| ref_dis_req_i | input | 1 | Request to switch the reference off |
| ref_dis_o | output | 1 | Reference switched off |
| cmp_o | output | CMP_W | Target count register |
| cal_o | output | CAL_W | Calibration code to oscillator trim |

## Verification
The bench builds the block with a 4-bit code, an 8-bit count, a target of 20 and a default code of 8. At this size it can sweep every starting code against periods below, at and above the target, which drives both saturation limits within a few steps. The 8-bit counter lets a 300-cycle period reach count saturation quickly. Retargeting to 254 and 255 then shows that saturation decides the step. Sleep entry with the loop on and with it off is then contrasted for retention against reload.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (run_i) chain_q[g] <= (g == 0) ? ref_i : chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign rise_o = run_i & chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fll_period_cnt.sv
module fll_period_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             edge_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             primed_q;

  assign cnt_inc = (cnt_q == CntMax) ? CntMax : cnt_q + 1'b1;
  assign meas_o  = cnt_inc;
  assign valid_o = run_i & ~clr_i & edge_i & primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (run_i) begin
      if (clr_i) begin
        cnt_q    <= '0;
        primed_q <= 1'b0;
      end else if (edge_i) begin
        cnt_q    <= '0;
        primed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/fll_cal_reg.sv
module fll_cal_reg
  import fll_pkg::*;
#(
  parameter int unsigned CAL_W   = 7,
  parameter int unsigned CAL_RST = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  step_e            step_i,
  input  logic             reload_i,
  input  logic             wr_i,
  input  logic [CAL_W-1:0] wdata_i,
  output logic [CAL_W-1:0] cal_o
);
  localparam logic [CAL_W-1:0] CalMax = {CAL_W{1'b1}};
  localparam logic [CAL_W-1:0] CalDef = CAL_W'(CAL_RST);

  logic [CAL_W-1:0] cal_q, cal_d;

  always_comb begin
    cal_d = cal_q;
    if (reload_i)      cal_d = CalDef;
    else if (wr_i)     cal_d = wdata_i;
    else begin
      unique case (step_i)
        STEP_UP: if (cal_q != CalMax) cal_d = cal_q + 1'b1;
        STEP_DN: if (cal_q != '0)     cal_d = cal_q - 1'b1;
        default: cal_d = cal_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cal_q <= CalDef;
    else if (run_i) cal_q <= cal_d;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/freq_lock_cal.sv
module freq_lock_cal
  import fll_pkg::*;
#(
  parameter int unsigned CAL_W       = 7,
  parameter int unsigned CMP_W       = 16,
  parameter int unsigned CMP_RST     = 1953,
  parameter int unsigned CAL_RST     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             enable_i,
  input  logic             sleep_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CMP_W-1:0] reg_wdata_i,
  input  logic             ref_dis_req_i,
  output logic             ref_dis_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic [CAL_W-1:0] cal_o
);
  localparam logic [CMP_W-1:0] CmpDef = CMP_W'(CMP_RST);

  logic             run;
  logic             ref_rise;
  logic             meas_valid;
  logic [CMP_W-1:0] meas;
  logic [CMP_W-1:0] cmp_q;
  logic             en_q;
  logic             reload_pend_q;
  logic             ref_dis_q;
  logic             en_rise;
  logic             reload;
  logic             cal_wr;
  step_e            step;

  assign run     = ~sleep_i;
  assign en_rise = enable_i & ~en_q;
  assign reload  = run & en_rise & reload_pend_q;
  assign cal_wr  = run & reg_wr_i & reg_sel_i & ~enable_i;

  fll_ref_sync #(
    .STAGES (SYNC_STAGES)
  ) i_ref_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .ref_i  (ref_i),
    .rise_o (ref_rise)
  );

  fll_period_cnt #(
    .CNT_W (CMP_W)
  ) i_period_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .clr_i   (~enable_i),
    .edge_i  (ref_rise),
    .valid_o (meas_valid),
    .meas_o  (meas)
  );

  always_comb begin
    step = STEP_HOLD;
    if (meas_valid) begin
      if (meas > cmp_q)      step = STEP_DN;
      else if (meas < cmp_q) step = STEP_UP;
    end
  end

  fll_cal_reg #(
    .CAL_W   (CAL_W),
    .CAL_RST (CAL_RST)
  ) i_cal_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .step_i   (step),
    .reload_i (reload),
    .wr_i     (cal_wr),
    .wdata_i  (reg_wdata_i[CAL_W-1:0]),
    .cal_o    (cal_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= CmpDef;
      en_q  <= 1'b0;
    end else if (run) begin
      en_q <= enable_i;
      if (reg_wr_i && !reg_sel_i) cmp_q <= reg_wdata_i;
    end
  end

  // reload armed only by a disabled sleep, consumed by the next enable rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 reload_pend_q <= 1'b0;
    else if (sleep_i && !enable_i) reload_pend_q <= 1'b1;
    else if (run && en_rise)     reload_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_dis_q <= 1'b0;
    else         ref_dis_q <= ref_dis_req_i & ~enable_i;
  end

  assign ref_dis_o = ref_dis_q;
  assign cmp_o     = cmp_q;
endmodule

// File: rtl/fll_checker.sv
module fll_checker #(
  parameter int unsigned CAL_W = 7,
  parameter int unsigned CMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             sleep_i,
  input logic             reg_wr_i,
  input logic             reg_sel_i,
  input logic [CMP_W-1:0] reg_wdata_i,
  input logic             ref_dis_o,
  input logic [CMP_W-1:0] cmp_o,
  input logic [CAL_W-1:0] cal_o,
  input logic             en_q
);
  localparam logic [CAL_W-1:0] CalMax = {CAL_W{1'b1}};

  logic looping;
  assign looping = enable_i & en_q & ~sleep_i;

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(looping) && (cal_o != $past(cal_o)) |->
      (cal_o == CAL_W'($past(cal_o) + 1'b1)) || (cal_o == CAL_W'($past(cal_o) - 1'b1)));

  assert_no_wrap_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(looping) && ($past(cal_o) == CalMax) |-> cal_o != '0);

  assert_no_wrap_bottom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(looping) && ($past(cal_o) == '0) |-> cal_o != CalMax);

  assert_cmp_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_wr_i && !reg_sel_i && !sleep_i) |-> cmp_o == $past(reg_wdata_i));

  assert_cal_manual_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_wr_i && reg_sel_i && !enable_i && !sleep_i) |->
      cal_o == $past(reg_wdata_i[CAL_W-1:0]));

  assert_sleep_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) |-> $stable(cal_o) && $stable(cmp_o));

  assert_ref_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_i) |-> !ref_dis_o);
endmodule

bind freq_lock_cal fll_checker #(
  .CAL_W (CAL_W),
  .CMP_W (CMP_W)
) i_fll_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .sleep_i     (sleep_i),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .ref_dis_o   (ref_dis_o),
  .cmp_o       (cmp_o),
  .cal_o       (cal_o),
  .en_q        (en_q)
);

// File: tb/test_freq_lock_cal.sv
module test_freq_lock_cal;
  localparam int CAL_W   = 4;
  localparam int CMP_W   = 8;
  localparam int CMP_RST = 20;
  localparam int CAL_RST = 8;
  localparam int CAL_MAX = (1 << CAL_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_i = 1'b0;
  logic             enable_i = 1'b0;
  logic             sleep_i = 1'b0;
  logic             reg_wr_i = 1'b0;
  logic             reg_sel_i = 1'b0;
  logic [CMP_W-1:0] reg_wdata_i = '0;
  logic             ref_dis_req_i = 1'b0;
  logic             ref_dis_o;
  logic [CMP_W-1:0] cmp_o;
  logic [CAL_W-1:0] cal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  freq_lock_cal #(
    .CAL_W   (CAL_W),
    .CMP_W   (CMP_W),
    .CMP_RST (CMP_RST),
    .CAL_RST (CAL_RST)
  ) i_freq_lock_cal (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ref_i         (ref_i),
    .enable_i      (enable_i),
    .sleep_i       (sleep_i),
    .reg_wr_i      (reg_wr_i),
    .reg_sel_i     (reg_sel_i),
    .reg_wdata_i   (reg_wdata_i),
    .ref_dis_req_i (ref_dis_req_i),
    .ref_dis_o     (ref_dis_o),
    .cmp_o         (cmp_o),
    .cal_o         (cal_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic periods(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      ref_i = 1'b1;
      cyc(p / 2);
      ref_i = 1'b0;
      cyc(p - p / 2);
    end
  endtask

  // disable, load code and target, enable, run n periods of p cycles
  task automatic scenario(input int cal0, input int tgt, input int p, input int n);
    enable_i = 1'b0; reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = CMP_W'(cal0);
    cyc(1);
    reg_sel_i = 1'b0; reg_wdata_i = CMP_W'(tgt);
    cyc(1);
    reg_wr_i = 1'b0; enable_i = 1'b1;
    cyc(2);
    periods(p, n);
  endtask

  function automatic int expect_cal(input int cal0, input int tgt, input int p, input int n);
    int meas = (p > (1 << CMP_W) - 1) ? (1 << CMP_W) - 1 : p;
    int v = cal0;
    for (int k = 1; k < n; k++) begin
      if (meas > tgt && v > 0) v--;
      else if (meas < tgt && v < CAL_MAX) v++;
    end
    return v;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int plist[5] = '{17, 19, 20, 21, 24};
    int held;
    cyc(2);
    chk("R1 cal reset", cal_o, CAL_RST);
    chk("R1 cmp reset", cmp_o, CMP_RST);
    chk("R1 ref_dis reset", ref_dis_o, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R2 R3 sweep every start code against each period
    for (int c = 0; c <= CAL_MAX; c++) begin
      foreach (plist[j]) begin
        scenario(c, CMP_RST, plist[j], 5);
        chk("R2 R3 step sweep", cal_o, expect_cal(c, CMP_RST, plist[j], 5));
      end
    end

    // R4 single period only primes
    scenario(5, CMP_RST, 17, 1);
    chk("R4 first edge discarded", cal_o, 5);
    periods(17, 1);
    chk("R4 second edge steps", cal_o, 6);

    // R11 count saturation
    scenario(7, 255, 300, 3);
    chk("R11 saturated equals target", cal_o, 7);
    scenario(7, 254, 300, 3);
    chk("R11 saturated above target", cal_o, 5);

    // R5 target writable while enabled
    reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 8'd33;
    cyc(1);
    reg_wr_i = 1'b0;
    chk("R5 cmp write enabled", cmp_o, 33);

    // R6 code write ignored while enabled
    held = cal_o;
    reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'd1;
    cyc(1);
    reg_wr_i = 1'b0;
    cyc(1);
    chk("R6 cal write ignored", cal_o, held);

    // R7 sleep freezes, resume keeps code
    scenario(9, CMP_RST, 19, 3);
    held = cal_o;
    chk("R7 pre-sleep value", held, 11);
    sleep_i = 1'b1;
    cyc(1);
    reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 8'd50;
    cyc(1);
    reg_sel_i = 1'b1; reg_wdata_i = 8'd2;
    cyc(1);
    reg_wr_i = 1'b0;
    periods(17, 3);
    chk("R7 cal frozen in sleep", cal_o, held);
    chk("R7 cmp frozen in sleep", cmp_o, CMP_RST);
    sleep_i = 1'b0;
    cyc(2);
    chk("R7 cal retained after wake", cal_o, held);

    // R9 enable rise without disabled sleep keeps manual code
    enable_i = 1'b0; reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'd3;
    cyc(1);
    reg_wr_i = 1'b0;
    chk("R6 manual write disabled", cal_o, 3);
    enable_i = 1'b1;
    cyc(2);
    chk("R9 no reload on plain enable", cal_o, 3);

    // R8 disabled sleep then enable reloads default
    enable_i = 1'b0; reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'd13;
    cyc(1);
    reg_wr_i = 1'b0;
    sleep_i = 1'b1;
    cyc(4);
    sleep_i = 1'b0;
    cyc(2);
    chk("R8 manual code kept over sleep", cal_o, 13);
    enable_i = 1'b1;
    cyc(2);
    chk("R8 reload after disabled sleep", cal_o, CAL_RST);

    // R10 reference lock
    ref_dis_req_i = 1'b1;
    cyc(2);
    chk("R10 lock while enabled", ref_dis_o, 0);
    enable_i = 1'b0;
    cyc(2);
    chk("R10 release when disabled", ref_dis_o, 1);
    ref_dis_req_i = 1'b0;
    cyc(2);
    chk("R10 follows request", ref_dis_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule